// File: doc/BRIEF.md
# Two-Word Burst Dual-Port SRAM Model

A synthesizable behavioural model of a quad-data-rate style static RAM. Reads and writes use separate ports, and every access moves a fixed burst of two words. Each rising clock edge samples two active-low command strobes, one for read and one for write. Each strobe has its own address bus, so one read, one write, both or neither can be issued in the same cycle. The double-data-rate data pins are folded into the core clock: both beats of a burst travel side by side on two word-wide buses.

A write command is followed one cycle later by its two data words and their per-lane byte enables. The write address waits in a single pending register until that data arrives, and is committed to the array at that edge. Read data comes back two cycles after the read command, with an output enable and a per-beat valid strobe that stand in for the data-valid echo clocks. A read also returns write data that has arrived but is not yet visible in the array, merged lane by lane.

Top module: `qdr2_burst_sram`

## Requirements
- R1: `rd_n_i` and `wr_n_i` are sampled on every rising edge of `clk_i` and a low level issues the command. A read and a write issued in the same cycle are both carried out, each at its own address.
- R2: A read at address A sampled at edge t drives `oe_o` high between edges t+2 and t+3. `rdata0_o` carries word A and `rdata1_o` carries word A with bit 0 inverted, so the burst wraps inside the aligned two-word pair.
- R3: For a write at address A sampled at edge t, `wdata0_i`/`wbe0_i` and `wdata1_i`/`wbe1_i` are sampled at edge t+1. They are stored at A and at A with bit 0 inverted respectively.
- R4: Byte lane k covers data bits [9k+8:9k]. Enable bit k at 1 writes that lane. A lane whose enable is 0 keeps its previous contents.
- R5: A read sampled at edge t returns the data of every write sampled at or before edge t+1, including the lane merge of R4, even though the write issued at t+1 is committed at the same edge the read data is captured.
- R6: A write sampled at edge t+2 or later has no effect on the data of a read sampled at edge t.
- R7: When no read is sampled at edge t, `oe_o` is low and both data outputs are zero between edges t+2 and t+3.
- R8: `beat_vld_o` is 2'b11 whenever `oe_o` is high and 2'b00 whenever it is low.
- R9: Asserting `rst_ni` low immediately clears `oe_o`, `beat_vld_o`, the data outputs and any pending write. Write data presented without a pending write command is ignored. Array contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_n_i | input | 1 | Read command, active low |
| rd_addr_i | input | ADDR_W | Read burst base address |
| wr_n_i | input | 1 | Write command, active low |
| wr_addr_i | input | ADDR_W | Write burst base address |
| wdata0_i | input | LANE_W*LANES | First write beat, one cycle after the command |
| wdata1_i | input | LANE_W*LANES | Second write beat, one cycle after the command |
| wbe0_i | input | LANES | Lane enables for the first beat |
| wbe1_i | input | LANES | Lane enables for the second beat |
| rdata0_o | output | LANE_W*LANES | First read beat |
| rdata1_o | output | LANE_W*LANES | Second read beat |
| beat_vld_o | output | 2 | Per-beat valid strobe |
| oe_o | output | 1 | Output enable; low means the data bus is released |

## Verification
Two things can land on the same edge: the commit of a pending write and the capture of read data from the same aligned pair. The bench provokes this by issuing a read and then, one cycle later, a write to the same base. It also writes to the pair-partner address, so the beats swap, and uses partial lane enables so that the merge with old contents is visible. The reference model applies each commit before it forms the read expectation for that edge, so a forwarding miss shows up as stale lanes. A write two cycles after the read must not leak in.

// File: rtl/qdr2_pkg.sv
`timescale 1ns/1ps
package qdr2_pkg;
  localparam int unsigned BEATS = 2;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_RW  = 2'b11
  } cmd_e;
endpackage

// File: rtl/qdr2_lane_merge.sv
`timescale 1ns/1ps
module qdr2_lane_merge #(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic [LANE_W*LANES-1:0] old_i,
  input  logic [LANE_W*LANES-1:0] new_i,
  input  logic [LANES-1:0]        be_i,
  output logic [LANE_W*LANES-1:0] out_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign out_o[l*LANE_W +: LANE_W] = be_i[l] ? new_i[l*LANE_W +: LANE_W]
                                               : old_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/qdr2_wr_pipe.sv
`timescale 1ns/1ps
module qdr2_wr_pipe #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_go_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic                   pend_v_o,
  output logic [1:0][ADDR_W-1:0] pend_a_o
);
  logic              v_q;
  logic [ADDR_W-1:0] a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0;
      a_q <= '0;
    end else begin
      v_q <= wr_go_i;
      if (wr_go_i) a_q <= addr_i;
    end
  end

  assign pend_v_o    = v_q;
  assign pend_a_o[0] = a_q;
  assign pend_a_o[1] = {a_q[ADDR_W-1:1], ~a_q[0]}; // wrap inside aligned pair
endmodule

// File: rtl/qdr2_store.sv
`timescale 1ns/1ps
module qdr2_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 18
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic [1:0][ADDR_W-1:0] wa_i,
  input  logic [1:0][DATA_W-1:0] wd_i,
  output logic [1:0][DATA_W-1:0] wold_o,
  input  logic [1:0][ADDR_W-1:0] ra_i,
  output logic [1:0][DATA_W-1:0] rd_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[wa_i[0]] <= wd_i[0];
      mem_q[wa_i[1]] <= wd_i[1];
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_port
    assign wold_o[b] = mem_q[wa_i[b]];
    assign rd_o[b]   = mem_q[ra_i[b]];
  end
endmodule

// File: rtl/qdr2_rd_pipe.sv
`timescale 1ns/1ps
module qdr2_rd_pipe #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 18
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_go_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic [1:0][ADDR_W-1:0] cap_a_o,
  input  logic [1:0][DATA_W-1:0] cap_d_i,
  output logic [1:0][DATA_W-1:0] q_o,
  output logic [1:0]             beat_o,
  output logic                   oe_o
);
  logic              s1_v, s2_v;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [1:0][DATA_W-1:0] q_q;
  logic [1:0]        beat_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      s1_a   <= '0;
      s2_v   <= 1'b0;
      s2_a   <= '0;
      q_q    <= '0;
      beat_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      s1_v   <= rd_go_i;
      s1_a   <= addr_i;
      s2_v   <= s1_v;
      s2_a   <= s1_a;
      oe_q   <= s2_v;
      beat_q <= {2{s2_v}};
      q_q    <= s2_v ? cap_d_i : '0; // zero stands for released bus
    end
  end

  assign cap_a_o[0] = s2_a;
  assign cap_a_o[1] = {s2_a[ADDR_W-1:1], ~s2_a[0]};
  assign q_o        = q_q;
  assign beat_o     = beat_q;
  assign oe_o       = oe_q;
endmodule

// File: rtl/qdr2_burst_sram.sv
`timescale 1ns/1ps
module qdr2_burst_sram
  import qdr2_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_n_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  input  logic                    wr_n_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LANE_W*LANES-1:0] wdata0_i,
  input  logic [LANE_W*LANES-1:0] wdata1_i,
  input  logic [LANES-1:0]        wbe0_i,
  input  logic [LANES-1:0]        wbe1_i,
  output logic [LANE_W*LANES-1:0] rdata0_o,
  output logic [LANE_W*LANES-1:0] rdata1_o,
  output logic [1:0]              beat_vld_o,
  output logic                    oe_o
);
  localparam int unsigned DATA_W = LANE_W * LANES;

  cmd_e cmd;
  logic rd_go, wr_go;

  assign cmd   = cmd_e'({~wr_n_i, ~rd_n_i});
  assign rd_go = (cmd == CMD_RD) || (cmd == CMD_RW);
  assign wr_go = (cmd == CMD_WR) || (cmd == CMD_RW);

  logic [BEATS-1:0][DATA_W-1:0] wd, wold, wmrg, rdw, capd, q;
  logic [BEATS-1:0][LANES-1:0]  wbe;
  logic [BEATS-1:0][ADDR_W-1:0] pend_a, cap_a;
  logic                         pend_v;

  assign wd  = {wdata1_i, wdata0_i};
  assign wbe = {wbe1_i, wbe0_i};

  qdr2_wr_pipe #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_go_i  (wr_go),
    .addr_i   (wr_addr_i),
    .pend_v_o (pend_v),
    .pend_a_o (pend_a)
  );

  qdr2_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (pend_v),
    .wa_i   (pend_a),
    .wd_i   (wmrg),
    .wold_o (wold),
    .ra_i   (cap_a),
    .rd_o   (rdw)
  );

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    logic              hit0, hit1;
    logic [DATA_W-1:0] fwd_d;
    logic [LANES-1:0]  fwd_be;

    // commit merge: enabled lanes replace array contents
    qdr2_lane_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_cmt (
      .old_i (wold[b]),
      .new_i (wd[b]),
      .be_i  (wbe[b]),
      .out_o (wmrg[b])
    );

    // forwarding: a commit on the capture edge is seen by the read
    assign hit0   = pend_v && (pend_a[0] == cap_a[b]);
    assign hit1   = pend_v && (pend_a[1] == cap_a[b]);
    assign fwd_d  = hit1 ? wd[1] : wd[0];
    assign fwd_be = hit1 ? wbe[1] : (hit0 ? wbe[0] : '0);

    qdr2_lane_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_fwd (
      .old_i (rdw[b]),
      .new_i (fwd_d),
      .be_i  (fwd_be),
      .out_o (capd[b])
    );
  end

  qdr2_rd_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_go_i (rd_go),
    .addr_i  (rd_addr_i),
    .cap_a_o (cap_a),
    .cap_d_i (capd),
    .q_o     (q),
    .beat_o  (beat_vld_o),
    .oe_o    (oe_o)
  );

  assign rdata0_o = q[0];
  assign rdata1_o = q[1];
endmodule

// File: rtl/qdr2_burst_sram_chk.sv
`timescale 1ns/1ps
module qdr2_burst_sram_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    rd_n_i,
  input logic [ADDR_W-1:0]       rd_addr_i,
  input logic                    wr_n_i,
  input logic [ADDR_W-1:0]       wr_addr_i,
  input logic [LANE_W*LANES-1:0] wdata0_i,
  input logic [LANE_W*LANES-1:0] wdata1_i,
  input logic [LANES-1:0]        wbe0_i,
  input logic [LANES-1:0]        wbe1_i,
  input logic [LANE_W*LANES-1:0] rdata0_o,
  input logic [LANE_W*LANES-1:0] rdata1_o,
  input logic [1:0]              beat_vld_o,
  input logic                    oe_o
);
  logic [1:0] age_q; // edges since reset release, saturating at 3

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !$past(rd_n_i, 3)) |-> oe_o); // R2

  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(rd_n_i, 3)) |-> (!oe_o && rdata0_o == '0 && rdata1_o == '0)); // R7

  AST_BEAT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_vld_o == {2{oe_o}}); // R8

  AST_FWD_BEAT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !$past(rd_n_i, 3) && !$past(wr_n_i, 2) &&
     $past(wr_addr_i, 2) == $past(rd_addr_i, 3) && $past(&wbe0_i, 1))
    |-> rdata0_o == $past(wdata0_i, 1)); // R5

  AST_FWD_BEAT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !$past(rd_n_i, 3) && !$past(wr_n_i, 2) &&
     $past(wr_addr_i, 2) == $past(rd_addr_i, 3) && $past(&wbe1_i, 1))
    |-> rdata1_o == $past(wdata1_i, 1)); // R5
endmodule

bind qdr2_burst_sram qdr2_burst_sram_chk #(
  .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
) u_chk (.*);

// File: tb/sim_qdr2_burst_sram.sv
`timescale 1ns/1ps
module sim_qdr2_burst_sram;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        rd_n_i, wr_n_i;
  logic [7:0]  rd_addr_i, wr_addr_i;
  logic [17:0] wdata0_i, wdata1_i;
  logic [1:0]  wbe0_i, wbe1_i;
  logic [17:0] rdata0_o, rdata1_o;
  logic [1:0]  beat_vld_o;
  logic        oe_o;

  qdr2_burst_sram u0 (.*);

  always #4 clk_i = ~clk_i; // 125 MHz

  int total = 0, bad = 0;
  bit done = 1'b0;
  string cur_tag = "R9";

  // reference state
  logic [17:0] ref_mem [256];
  logic        pw_v, rq1_v, rq2_v, exp_v;
  logic [7:0]  pw_a, rq1_a, rq2_a;
  logic [17:0] hd0, hd1, exp0, exp1, stray_d;
  logic [1:0]  hb0, hb1;

  function automatic logic [7:0] mate(input logic [7:0] a);
    return {a[7:1], ~a[0]};
  endfunction

  function automatic logic [17:0] pat(input logic [7:0] a, input logic [7:0] s);
    return {s, a, 2'b10};
  endfunction

  function automatic logic [17:0] mrg(input logic [17:0] o, n, input logic [1:0] be);
    return {be[1] ? n[17:9] : o[17:9], be[0] ? n[8:0] : o[8:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [17:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_out();
    if (exp_v) begin
      check(oe_o === 1'b1 && beat_vld_o === 2'b11, "R8", {15'd0, beat_vld_o, oe_o}, 18'h7);
      check(rdata0_o === exp0, cur_tag, rdata0_o, exp0);
      check(rdata1_o === exp1, cur_tag, rdata1_o, exp1);
    end else begin
      check(oe_o === 1'b0 && beat_vld_o === 2'b00, "R7", {15'd0, beat_vld_o, oe_o}, 18'h0);
      check(rdata0_o === 18'd0 && rdata1_o === 18'd0, "R7", rdata0_o | rdata1_o, 18'd0);
    end
  endtask

  // one core cycle; write data given here is delivered on the next cycle
  task automatic step(input bit rd, input logic [7:0] ra, input bit wr, input logic [7:0] wa,
                      input logic [17:0] d0 = '0, d1 = '0, input logic [1:0] b0 = 2'b11,
                      b1 = 2'b11);
    @(negedge clk_i);
    chk_out();
    rd_n_i = ~rd; rd_addr_i = ra; wr_n_i = ~wr; wr_addr_i = wa;
    if (pw_v) begin
      wdata0_i = hd0; wdata1_i = hd1; wbe0_i = hb0; wbe1_i = hb1;
      ref_mem[pw_a]       = mrg(ref_mem[pw_a], hd0, hb0);
      ref_mem[mate(pw_a)] = mrg(ref_mem[mate(pw_a)], hd1, hb1);
    end else begin
      wdata0_i = stray_d; wdata1_i = ~stray_d; wbe0_i = 2'b11; wbe1_i = 2'b11;
    end
    exp_v = rq2_v;
    if (rq2_v) begin
      exp0 = ref_mem[rq2_a];
      exp1 = ref_mem[mate(rq2_a)];
    end
    rq2_v = rq1_v; rq2_a = rq1_a; rq1_v = rd; rq1_a = ra;
    pw_v = wr; pw_a = wa; hd0 = d0; hd1 = d1; hb0 = b0; hb1 = b1;
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; rd_n_i = 1'b1; wr_n_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check(oe_o === 1'b0 && beat_vld_o === 2'b00, "R9", {15'd0, beat_vld_o, oe_o}, 18'h0);
    check(rdata0_o === 18'd0 && rdata1_o === 18'd0, "R9", rdata0_o | rdata1_o, 18'd0);
    rst_ni = 1'b1;
    pw_v = 0; rq1_v = 0; rq2_v = 0; exp_v = 0;
  endtask

  // R3: fill pairs 0..31 with full enables, back to back
  task automatic t_fill();
    cur_tag = "R3";
    for (int a = 0; a < 32; a += 2) step(0, 0, 1, 8'(a), pat(8'(a), 1), pat(8'(a + 1), 1));
    drain();
  endtask

  // R2: even and odd bases, odd ones wrap inside the pair
  task automatic t_read();
    cur_tag = "R2";
    for (int a = 0; a < 16; a += 2) step(1, 8'(a), 0, 0);
    step(1, 8'd1, 0, 0);
    step(1, 8'd5, 0, 0);
    step(1, 8'd31, 0, 0);
    drain();
  endtask

  // R7 gaps and R1 read plus write in one cycle
  task automatic t_mix();
    cur_tag = "R1";
    step(1, 8'd0, 0, 0);
    step(0, 0, 0, 0);
    step(1, 8'd2, 0, 0);
    step(1, 8'd20, 1, 8'd40, pat(8'd40, 2), pat(8'd41, 2));
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(1, 8'd40, 0, 0);
    drain();
  endtask

  // R4: partial lane enables keep old lanes
  task automatic t_bytes();
    cur_tag = "R4";
    step(0, 0, 1, 8'd4, pat(8'd4, 8'hA5), pat(8'd5, 8'hA5), 2'b01, 2'b10);
    step(0, 0, 1, 8'd17, pat(8'd17, 8'h5A), pat(8'd16, 8'h5A), 2'b10, 2'b00);
    step(0, 0, 0, 0);
    step(1, 8'd4, 0, 0);
    step(1, 8'd16, 0, 0);
    drain();
  endtask

  // R5: writes that commit on the read capture edge are forwarded
  task automatic t_fwd();
    cur_tag = "R5";
    step(1, 8'd6, 0, 0);
    step(0, 0, 1, 8'd6, pat(8'd6, 3), pat(8'd7, 3), 2'b10, 2'b11);
    drain();
    step(1, 8'd8, 1, 8'd9, pat(8'd9, 5), pat(8'd8, 5));
    step(1, 8'd10, 0, 0);
    step(0, 0, 1, 8'd11, pat(8'd11, 6), pat(8'd10, 6), 2'b01, 2'b10);
    step(1, 8'd24, 1, 8'd25, pat(8'd25, 9), pat(8'd24, 9));
    step(0, 0, 1, 8'd24, pat(8'd24, 8'hC3), pat(8'd25, 8'hC3), 2'b11, 2'b01);
    drain();
  endtask

  // R6: a write two cycles after a read stays invisible to it
  task automatic t_order();
    cur_tag = "R6";
    step(1, 8'd12, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 1, 8'd12, pat(8'd12, 4), pat(8'd13, 4));
    drain();
    step(1, 8'd12, 0, 0);
    drain();
  endtask

  // R9: reset drops a pending write; stray data is ignored
  task automatic t_rst_pend();
    cur_tag = "R9";
    stray_d = pat(8'd14, 7);
    step(0, 0, 1, 8'd14, pat(8'd14, 7), pat(8'd15, 7));
    do_reset();
    step(1, 8'd14, 0, 0);
    step(1, 8'd0, 0, 0);
    drain();
    stray_d = 18'h3FFFF;
  endtask

  initial begin
    rst_ni = 1'b0; rd_n_i = 1'b1; wr_n_i = 1'b1; rd_addr_i = '0; wr_addr_i = '0;
    wdata0_i = '0; wdata1_i = '0; wbe0_i = '0; wbe1_i = '0;
    stray_d = 18'h3FFFF;
    pw_v = 0; rq1_v = 0; rq2_v = 0; exp_v = 0;
    pw_a = '0; rq1_a = '0; rq2_a = '0; hd0 = '0; hd1 = '0; hb0 = '0; hb1 = '0;
    exp0 = '0; exp1 = '0;
    do_reset();
    t_fill();
    t_read();
    t_mix();
    t_bytes();
    t_fwd();
    t_order();
    t_rst_pend();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule